// File: doc/BRIEF.md
# Outstanding-Packet Watchdog Timer

This block keeps count of high-priority management packets that have been queued for transmission and have not yet completed. When the count leaves zero, a countdown starts. Each completion that leaves packets outstanding restarts the countdown from the full interval. When the last outstanding packet completes, the countdown stops without any action. If the countdown runs out while packets remain outstanding, the block raises a cancel-all-sends pulse and a head-of-line-down pulse for one cycle. Neighbouring logic then performs the flush.

The countdown advances only on a time-base strobe. Its length is one twentieth of the number of strobes per second, rounded up. A dequeue strobe with nothing outstanding is treated as a protocol error. That dequeue is ignored, and a sticky error flag is raised.

Top module: `pkt_wdog`

## Requirements
- R1: An enqueue alone (dequeue low) at count 0 sets the count to 1 and starts the countdown at the full interval.
- R2: An enqueue alone at a nonzero count raises the count by one and does not restart the running countdown.
- R3: A dequeue alone at a count of 2 or more lowers the count by one and restarts the countdown at the full interval.
- R4: A dequeue alone at count 1 sets the count to 0 and stops the countdown. No cancel or head-of-line-down pulse follows, however many strobes arrive afterwards.
- R5: The interval is (UNITS_PER_SEC + 19) / 20 time-base strobes. The countdown moves only on cycles with tick_i high, and a strobe in the cycle that starts or restarts it is not counted.
- R6: On the interval-th counted strobe, with the count nonzero, cancel_o and hol_down_o are both high for exactly one cycle, starting the cycle after that strobe. The countdown then stays stopped until R1, R3 or R7 restarts it.
- R7: Enqueue and dequeue in the same cycle leave the count unchanged. They restart the countdown if the count is nonzero, and do nothing if it is zero.
- R8: A dequeue alone at count 0 leaves the count at 0 and sets underflow_o. underflow_o then stays high until reset.
- R9: Synchronous reset (rst high at a clock edge) clears the count and underflow_o, stops the countdown and clears both pulses.
- R10: An enqueue alone at the maximum count 2^CNT_W - 1 leaves the count unchanged.
- R11: A restart and the final strobe in the same cycle: the restart wins, and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_i | input | 1 | Packet queued strobe |
| deq_i | input | 1 | Packet completed strobe |
| tick_i | input | 1 | Time-base strobe |
| cancel_o | output | 1 | Cancel-all-sends pulse |
| hol_down_o | output | 1 | Head-of-line-down pulse |
| count_o | output | CNT_W | Outstanding packet count |
| underflow_o | output | 1 | Sticky dequeue-at-zero error |

## Verification
A wrong count shows on count_o one cycle after the offending strobe. It also shows later, as a missing or spurious stop when the count should reach zero. A countdown that restarts at the wrong moment, or fails to stop, stays hidden until the interval runs out. It then appears as a pulse one or more strobes early or late, or as a pulse after the count has returned to zero. For this reason each scenario counts strobes exactly and checks the quiet strobes before the expected pulse as well as the pulse itself. A faulty error flag shows directly on underflow_o, including the case where a later legal enqueue drops it.

// File: rtl/pkt_wdog.sv
module pkt_wdog #(
  parameter int CNT_W         = 8,
  parameter int UNITS_PER_SEC = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_i,
  input  logic             deq_i,
  input  logic             tick_i,
  output logic             cancel_o,
  output logic             hol_down_o,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam int INTERVAL = (UNITS_PER_SEC + 19) / 20;
  localparam int TMR_W    = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(INTERVAL);

  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] rem_q;
  logic             armed_q, uf_q, fire_q;

  wire is_zero = (cnt_q == '0);
  wire is_one  = (cnt_q == CNT_W'(1));
  wire enq_only = enq_i & ~deq_i;
  wire deq_only = deq_i & ~enq_i;

  wire inc    = enq_only & (cnt_q != CNT_MAX);
  wire dec    = deq_only & ~is_zero;
  wire bad    = deq_only & is_zero;
  wire start  = enq_only & is_zero;
  wire reload = (dec & ~is_one) | (enq_i & deq_i & ~is_zero);
  wire stop   = dec & is_one;
  wire last   = tick_i & armed_q & (rem_q == TMR_W'(1));
  wire expire = last & ~start & ~reload & ~stop & ~is_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      armed_q <= 1'b0;
      uf_q    <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      if (inc)      cnt_q <= cnt_q + CNT_W'(1);
      else if (dec) cnt_q <= cnt_q - CNT_W'(1);
      if (bad) uf_q <= 1'b1;
      if (start | reload) begin
        armed_q <= 1'b1;
        rem_q   <= TMR_LOAD;
      end else if (stop) begin
        armed_q <= 1'b0;
      end else if (tick_i & armed_q) begin
        if (rem_q == TMR_W'(1)) armed_q <= 1'b0;
        else                    rem_q   <= rem_q - TMR_W'(1);
      end
      fire_q <= expire;
    end
  end

  assign cancel_o    = fire_q;
  assign hol_down_o  = fire_q;
  assign count_o     = cnt_q;
  assign underflow_o = uf_q;
endmodule

module pkt_wdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_i,
  input logic             deq_i,
  input logic             cancel_o,
  input logic             hol_down_o,
  input logic [CNT_W-1:0] count_o,
  input logic             underflow_o
);
  // R6
  pulse_pair_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_o == hol_down_o);
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_o |=> !cancel_o);
  // R6
  pulse_needs_work_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_o |-> count_o != '0);
  // R2
  count_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (enq_i && !deq_i && count_o != {CNT_W{1'b1}}) |=> count_o == $past(count_o) + CNT_W'(1));
  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enq_i && deq_i) |=> count_o == $past(count_o));
  // R8
  underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (deq_i && !enq_i && count_o == '0) |=> underflow_o && count_o == '0);
  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |=> underflow_o);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !underflow_o && !cancel_o && !hol_down_o));
endmodule

bind pkt_wdog pkt_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enq_i(enq_i), .deq_i(deq_i),
  .cancel_o(cancel_o), .hol_down_o(hol_down_o),
  .count_o(count_o), .underflow_o(underflow_o)
);

// File: tb/sim_pkt_wdog.sv
module sim_pkt_wdog;
  localparam int CNT_W = 3;
  localparam int UNITS = 100;
  localparam int IVL   = (UNITS + 19) / 20;

  logic clk = 1'b0, rst = 1'b1, enq = 1'b0, deq = 1'b0, tick = 1'b0;
  logic cancel, hol, uf;
  logic [CNT_W-1:0] count;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pkt_wdog #(.CNT_W(CNT_W), .UNITS_PER_SEC(UNITS)) u0 (
    .clk(clk), .rst(rst), .enq_i(enq), .deq_i(deq), .tick_i(tick),
    .cancel_o(cancel), .hol_down_o(hol), .count_o(count), .underflow_o(uf));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic e, logic d, logic t);
    enq = e; deq = d; tick = t;
    @(negedge clk);
    enq = 0; deq = 0; tick = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic quiet_ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 1);
      chk(tag, {cancel, hol}, 0);
    end
  endtask

  task automatic expect_fire(string tag);
    step(0, 0, 1);
    chk(tag, {cancel, hol}, 3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    do_reset();
    chk("R9 reset count", count, 0);
    chk("R9 reset underflow", uf, 0);
    chk("R9 reset pulses", {cancel, hol}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    step(1, 0, 0);
    chk("R1 count after first enq", count, 1);
    quiet_ticks(IVL - 1, "R5 quiet before expiry");
    expect_fire("R6 fire on interval tick");
    step(0, 0, 0);
    chk("R6 pulse one cycle", {cancel, hol}, 0);
    quiet_ticks(2 * IVL, "R6 stays stopped");
    chk("R6 count kept", count, 1);
  endtask

  task automatic t_no_retrigger();
    do_reset();
    step(1, 0, 0);
    quiet_ticks(3, "R2 first ticks");
    step(1, 0, 0);
    chk("R2 count two", count, 2);
    quiet_ticks(IVL - 4, "R2 quiet");
    expect_fire("R2 fire not restarted");
  endtask

  task automatic t_deq_reload();
    do_reset();
    step(1, 0, 0);
    step(1, 0, 0);
    quiet_ticks(3, "R3 pre ticks");
    step(0, 1, 0);
    chk("R3 count one", count, 1);
    quiet_ticks(IVL - 1, "R3 quiet after reload");
    expect_fire("R3 fire full interval");
  endtask

  task automatic t_deq_stop();
    do_reset();
    step(1, 0, 0);
    quiet_ticks(3, "R4 pre ticks");
    step(0, 1, 0);
    chk("R4 count zero", count, 0);
    quiet_ticks(3 * IVL, "R4 no pulse when stopped");
    chk("R4 no underflow", uf, 0);
  endtask

  task automatic t_simul();
    do_reset();
    step(1, 1, 0);
    chk("R7 zero count stays", count, 0);
    chk("R7 no underflow", uf, 0);
    quiet_ticks(2 * IVL, "R7 zero no timer");
    step(1, 0, 0);
    quiet_ticks(3, "R7 pre ticks");
    step(1, 1, 0);
    chk("R7 count unchanged", count, 1);
    quiet_ticks(IVL - 1, "R7 quiet after reload");
    expect_fire("R7 fire after reload");
  endtask

  task automatic t_underflow();
    do_reset();
    step(0, 1, 0);
    chk("R8 count stays zero", count, 0);
    chk("R8 flag set", uf, 1);
    step(1, 0, 0);
    chk("R8 flag sticky", uf, 1);
    chk("R8 count after enq", count, 1);
    quiet_ticks(2, "R8 ticks");
    do_reset();
    chk("R9 clears flag", uf, 0);
    chk("R9 clears count", count, 0);
    quiet_ticks(2 * IVL, "R9 timer stopped");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 9; i++) step(1, 0, 0);
    chk("R10 saturated count", count, 7);
    step(0, 1, 0);
    chk("R10 dec from max", count, 6);
  endtask

  task automatic t_priority();
    do_reset();
    step(1, 0, 0);
    step(1, 0, 0);
    quiet_ticks(IVL - 1, "R11 pre ticks");
    step(0, 1, 1);
    chk("R11 no pulse on restart", {cancel, hol}, 0);
    chk("R11 count", count, 1);
    quiet_ticks(IVL - 1, "R11 quiet");
    expect_fire("R11 fire after restart");
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_no_retrigger();
    t_deq_reload();
    t_deq_stop();
    t_simul();
    t_underflow();
    t_saturate();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule